// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block resolves where execution goes after one control-transfer instruction. It takes these inputs:

- the current program counter;
- a decoded 6-bit operation code;
- the 26-bit jump field and a 16-bit branch displacement;
- two source register values;
- the floating-point condition flag.

One cycle after a request strobe it presents these outputs:

- the computed target address;
- the next program counter;
- a taken flag;
- a link-register write (enable, register index, value);
- an alignment-fault flag.

Instructions occupy 8 bytes, so both the fall-through address and the return address written by linking operations equal the current PC plus 8.

The operations are:

- direct jumps within the current 256 MiB region;
- register-indirect jumps, whose address must be 8-byte aligned;
- linking forms of both kinds of jump;
- signed integer compare branches;
- branches on the floating-point flag.

A branch target is computed and shown whether or not the branch is taken, so a fetch stage or predictor can use it in either case.

Top module: `npc_unit`

## Requirements
- R1: While reset is active and after it is released, before any request, every output is zero.
- R2: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. Without a request, all other outputs hold their previous values.
- R3: Opcode 0x00, and any opcode above 0x0c, yields these outputs: next PC = target PC = PC+8, taken low, link enable low, fault low.
- R4: Opcode 0x01 (jump) yields target = {PC[31:28], jump field, 2'b00}, taken high and no link write.
- R5: Opcode 0x02 (jump and link) jumps as in R4 and writes PC+8 into register 31.
- R6: Opcodes 0x03 (indirect jump) and 0x04 (indirect jump and link) with `src_a[2:0]` equal to 0 take target = `src_a`. Opcode 0x04 also writes PC+8 into register `rd_idx`.
- R7: For opcodes 0x03 and 0x04, if `src_a[2:0]` is nonzero, the fault flag is raised. The target is still `src_a`, but taken is low, the link write is suppressed and next PC = PC+8.
- R8: For opcodes 0x05 to 0x0c, target = PC + 8 + (sign-extended displacement << 2), whether or not the branch is taken.
- R9: Opcode 0x05 is taken when `src_a` == `src_b`; opcode 0x06 is taken when `src_a` != `src_b`.
- R10: Opcodes 0x07, 0x08, 0x09 and 0x0a are taken when the signed value of `src_a` is <=0, >0, <0 and >=0 respectively.
- R11: Opcode 0x0b is taken when `fp_flag` is 0; opcode 0x0c is taken when `fp_flag` is 1.
- R12: All address arithmetic wraps modulo 2^32.
- R13: When taken is high, next PC equals target PC; otherwise next PC equals PC+8.
- R14: When the link enable is low, the link index and link value read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; inputs are sampled on this cycle |
| cur_pc | input | 32 | Address of the instruction being resolved |
| opcode | input | 6 | Decoded operation code |
| jmp_field | input | 26 | Direct-jump word index |
| br_disp | input | 16 | Signed branch displacement in words |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| rd_idx | input | 5 | Link destination for indirect jump and link |
| fp_flag | input | 1 | Floating-point condition flag |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| target_pc | output | 32 | Computed transfer address |
| next_pc | output | 32 | Address of the next instruction to fetch |
| taken | output | 1 | Transfer is taken |
| link_we | output | 1 | Link-register write enable |
| link_idx | output | 5 | Link-register index |
| link_val | output | 32 | Return address to write |
| align_fault | output | 1 | Misaligned indirect target |

## Verification
The assertions check on every cycle the properties that link outputs to earlier inputs:

- the one-cycle result strobe;
- output hold between requests;
- next PC following the target when taken and PC+8 otherwise;
- the return-address value;
- the fault flag blocking both link and taken, and being raised only when the low source bits were nonzero.

What the assertions cannot show is whether each opcode picks the correct condition and target formula. That includes:

- the signed compare boundaries at zero and at the most negative value;
- region-preserving direct targets;
- wraparound past the top of the address space;
- unknown opcodes falling back to a plain advance.

The bench's directed and seeded random scenarios cover these against an independent model.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN       = 32;
  localparam int OPC_W      = 6;
  localparam int JF_W       = 26;
  localparam int OFS_W      = 16;
  localparam int RIDX_W     = 5;
  localparam int INST_BYTES = 8;
  localparam int ALIGN_BITS = 3;
  localparam int LINK_REG   = 31;
  localparam int REGION_W   = XLEN - JF_W - 2;

  typedef enum logic [OPC_W-1:0] {
    OP_IDLE  = 6'h00,
    OP_JMP   = 6'h01,
    OP_JMPL  = 6'h02,
    OP_JREG  = 6'h03,
    OP_JREGL = 6'h04,
    OP_BEQ   = 6'h05,
    OP_BNE   = 6'h06,
    OP_BLE0  = 6'h07,
    OP_BGT0  = 6'h08,
    OP_BLT0  = 6'h09,
    OP_BGE0  = 6'h0a,
    OP_FPF   = 6'h0b,
    OP_FPT   = 6'h0c
  } op_e;

  // sequential address after one instruction
  function automatic logic [XLEN-1:0] fn_fallthru(input logic [XLEN-1:0] pc);
    return pc + XLEN'(INST_BYTES);
  endfunction

  // region-preserving direct jump address
  function automatic logic [XLEN-1:0] fn_jump_target(input logic [XLEN-1:0] pc,
                                                     input logic [JF_W-1:0] jf);
    return {pc[XLEN-1 -: REGION_W], jf, 2'b00};
  endfunction

  // PC-relative branch address, word displacement
  function automatic logic [XLEN-1:0] fn_branch_target(input logic [XLEN-1:0]  pc,
                                                       input logic [OFS_W-1:0] disp);
    logic [XLEN-1:0] sx;
    sx = {{(XLEN-OFS_W){disp[OFS_W-1]}}, disp};
    return fn_fallthru(pc) + (sx << 2);
  endfunction

  function automatic logic fn_misaligned(input logic [XLEN-1:0] addr);
    return |addr[ALIGN_BITS-1:0];
  endfunction
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic             fp_flag,
  output logic             is_branch,
  output logic             cond_true
);
  logic a_zero, a_neg;
  assign a_zero = (src_a == '0);
  assign a_neg  = src_a[XLEN-1];

  always_comb begin
    is_branch = 1'b1;
    cond_true = 1'b0;
    case (opcode)
      OP_BEQ:  cond_true = (src_a == src_b);
      OP_BNE:  cond_true = (src_a != src_b);
      OP_BLE0: cond_true = a_neg | a_zero;
      OP_BGT0: cond_true = ~a_neg & ~a_zero;
      OP_BLT0: cond_true = a_neg;
      OP_BGE0: cond_true = ~a_neg;
      OP_FPF:  cond_true = ~fp_flag;
      OP_FPT:  cond_true = fp_flag;
      default: is_branch = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [JF_W-1:0]  jmp_field,
  input  logic [OFS_W-1:0] br_disp,
  input  logic [XLEN-1:0]  src_a,
  output logic             is_direct,
  output logic             is_indirect,
  output logic             misaligned,
  output logic [XLEN-1:0]  fallthru,
  output logic [XLEN-1:0]  target
);
  logic [XLEN-1:0] jump_t, branch_t;

  assign fallthru    = fn_fallthru(cur_pc);
  assign jump_t      = fn_jump_target(cur_pc, jmp_field);
  assign branch_t    = fn_branch_target(cur_pc, br_disp);
  assign is_direct   = (opcode == OP_JMP)  || (opcode == OP_JMPL);
  assign is_indirect = (opcode == OP_JREG) || (opcode == OP_JREGL);
  assign misaligned  = is_indirect && fn_misaligned(src_a);

  always_comb begin
    if (is_direct)                                    target = jump_t;
    else if (is_indirect)                             target = src_a;
    else if (opcode >= OP_BEQ && opcode <= OP_FPT)    target = branch_t;
    else                                              target = fallthru;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [JF_W-1:0]   jmp_field,
  input  logic [OFS_W-1:0]  br_disp,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  input  logic [RIDX_W-1:0] rd_idx,
  input  logic              fp_flag,
  output logic              res_valid,
  output logic [XLEN-1:0]   target_pc,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_val,
  output logic              align_fault
);
  logic            is_branch, cond_true;
  logic            is_direct, is_indirect, misaligned;
  logic [XLEN-1:0] fallthru, target_d;

  logic              taken_d, link_d;
  logic [RIDX_W-1:0] lidx_d;

  npc_cond_eval u_cond (
    .opcode    (opcode),
    .src_a     (src_a),
    .src_b     (src_b),
    .fp_flag   (fp_flag),
    .is_branch (is_branch),
    .cond_true (cond_true)
  );

  npc_target_gen u_tgt (
    .opcode      (opcode),
    .cur_pc      (cur_pc),
    .jmp_field   (jmp_field),
    .br_disp     (br_disp),
    .src_a       (src_a),
    .is_direct   (is_direct),
    .is_indirect (is_indirect),
    .misaligned  (misaligned),
    .fallthru    (fallthru),
    .target      (target_d)
  );

  // decision: what is taken and who links
  always_comb begin
    taken_d = 1'b0;
    link_d  = 1'b0;
    lidx_d  = '0;
    if (is_direct) begin
      taken_d = 1'b1;
      link_d  = (opcode == OP_JMPL);
      lidx_d  = link_d ? RIDX_W'(LINK_REG) : '0;
    end else if (is_indirect) begin
      taken_d = ~misaligned;
      link_d  = (opcode == OP_JREGL) && ~misaligned;
      lidx_d  = link_d ? rd_idx : '0;
    end else if (is_branch) begin
      taken_d = cond_true;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      target_pc   <= '0;
      next_pc     <= '0;
      taken       <= 1'b0;
      link_we     <= 1'b0;
      link_idx    <= '0;
      link_val    <= '0;
      align_fault <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        target_pc   <= target_d;
        next_pc     <= taken_d ? target_d : fallthru;
        taken       <= taken_d;
        link_we     <= link_d;
        link_idx    <= lidx_d;
        link_val    <= link_d ? fallthru : '0;
        align_fault <= misaligned;
      end
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [XLEN-1:0]   cur_pc,
  input logic [XLEN-1:0]   src_a,
  input logic              res_valid,
  input logic [XLEN-1:0]   target_pc,
  input logic [XLEN-1:0]   next_pc,
  input logic              taken,
  input logic              link_we,
  input logic [RIDX_W-1:0] link_idx,
  input logic [XLEN-1:0]   link_val,
  input logic              align_fault
);
  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  p_nostrobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(next_pc) && $stable(target_pc) && $stable(link_we)));

  p_follow_target_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && taken) |-> (next_pc == target_pc));

  p_fallthru_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !taken) |-> (next_pc == $past(cur_pc) + 32'd8));

  p_link_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && link_we) |-> (link_val == $past(cur_pc) + 32'd8));

  p_fault_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> (!link_we && !taken));

  p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && align_fault) |-> ($past(src_a[ALIGN_BITS-1:0]) != '0));

  p_idle_link_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !link_we |-> (link_idx == '0 && link_val == '0));
endmodule

bind npc_unit npc_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .cur_pc      (cur_pc),
  .src_a       (src_a),
  .res_valid   (res_valid),
  .target_pc   (target_pc),
  .next_pc     (next_pc),
  .taken       (taken),
  .link_we     (link_we),
  .link_idx    (link_idx),
  .link_val    (link_val),
  .align_fault (align_fault)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [5:0]  opcode = '0;
  logic [25:0] jmp_field = '0;
  logic [15:0] br_disp = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [4:0]  rd_idx = '0;
  logic        fp_flag = 1'b0;
  logic        res_valid, taken, link_we, align_fault;
  logic [31:0] target_pc, next_pc, link_val;
  logic [4:0]  link_idx;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_pc(cur_pc),
    .opcode(opcode), .jmp_field(jmp_field), .br_disp(br_disp),
    .src_a(src_a), .src_b(src_b), .rd_idx(rd_idx), .fp_flag(fp_flag),
    .res_valid(res_valid), .target_pc(target_pc), .next_pc(next_pc),
    .taken(taken), .link_we(link_we), .link_idx(link_idx),
    .link_val(link_val), .align_fault(align_fault)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] op);
    case (op)
      6'h01: return "R4";
      6'h02: return "R5";
      6'h03, 6'h04: return "R6";
      6'h05, 6'h06: return "R9";
      6'h07, 6'h08, 6'h09, 6'h0a: return "R10";
      6'h0b, 6'h0c: return "R11";
      default: return "R3";
    endcase
  endfunction

  // independent model: returns {taken, link_we, fault}, target, next, idx
  task automatic model(output logic [31:0] tgt, output logic [31:0] nxt,
                       output logic tk, output logic lw, output logic [4:0] li,
                       output logic flt);
    logic [31:0] seq, disp32;
    seq = cur_pc + 32'd8;
    disp32 = 32'($signed(br_disp)) * 4;
    tk = 0; lw = 0; li = 0; flt = 0; tgt = seq;
    case (opcode)
      6'h01, 6'h02: begin
        tgt = (cur_pc & 32'hF000_0000) | ({6'd0, jmp_field} * 4);
        tk = 1;
        if (opcode == 6'h02) begin lw = 1; li = 5'd31; end
      end
      6'h03, 6'h04: begin
        tgt = src_a;
        flt = (src_a % 8) != 0;
        tk = !flt;
        if (opcode == 6'h04 && !flt) begin lw = 1; li = rd_idx; end
      end
      6'h05, 6'h06, 6'h07, 6'h08, 6'h09, 6'h0a, 6'h0b, 6'h0c: begin
        tgt = seq + disp32;
        case (opcode)
          6'h05: tk = (src_a == src_b);
          6'h06: tk = (src_a != src_b);
          6'h07: tk = ($signed(src_a) <= 0);
          6'h08: tk = ($signed(src_a) > 0);
          6'h09: tk = ($signed(src_a) < 0);
          6'h0a: tk = ($signed(src_a) >= 0);
          6'h0b: tk = (fp_flag == 0);
          default: tk = (fp_flag == 1);
        endcase
      end
      default: ;
    endcase
    nxt = tk ? tgt : seq;
  endtask

  task automatic issue(input string req);
    logic [31:0] e_tgt, e_nxt, e_lval;
    logic e_tk, e_lw, e_flt;
    logic [4:0] e_li;
    model(e_tgt, e_nxt, e_tk, e_lw, e_li, e_flt);
    e_lval = e_lw ? cur_pc + 32'd8 : 32'd0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "res_valid", {31'd0, res_valid}, 32'd1);
    chk(req, "target_pc", target_pc, e_tgt);
    chk(req, "next_pc", next_pc, e_nxt);
    chk(req, "taken", {31'd0, taken}, {31'd0, e_tk});
    chk(req, "link_we", {31'd0, link_we}, {31'd0, e_lw});
    chk("R14", "link_idx", {27'd0, link_idx}, {27'd0, e_li});
    chk("R14", "link_val", link_val, e_lval);
    chk(req, "align_fault", {31'd0, align_fault}, {31'd0, e_flt});
  endtask

  task automatic setin(input logic [5:0] op, input logic [31:0] pc,
                       input logic [31:0] a, input logic [31:0] b);
    opcode = op; cur_pc = pc; src_a = a; src_b = b;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        done = 1;
      end
    end
  end

  initial begin
    logic [31:0] hold_n, hold_t;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "res_valid", {31'd0, res_valid}, 32'd0);
    chk("R1", "next_pc", next_pc, 32'd0);
    chk("R1", "target_pc", target_pc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "link_we", {31'd0, link_we}, 32'd0);
    chk("R1", "align_fault", {31'd0, align_fault}, 32'd0);

    // R3 plain advance and unknown opcodes
    setin(6'h00, 32'h0000_1000, 0, 0); issue("R3");
    setin(6'h0d, 32'h0000_2000, 0, 0); issue("R3");
    setin(6'h3f, 32'h1234_5678, 0, 0); issue("R3");
    // R4 direct jump keeps region bits
    jmp_field = 26'h3FF_FFFF; setin(6'h01, 32'hA000_0010, 0, 0); issue("R4");
    // R5 jump and link into register 31
    jmp_field = 26'h000_0004; setin(6'h02, 32'h7FFF_FFF0, 0, 0); issue("R5");
    // R6 aligned indirect jumps, with and without link
    rd_idx = 5'd9; setin(6'h03, 32'h100, 32'h0000_8008, 0); issue("R6");
    setin(6'h04, 32'h200, 32'hFFFF_FFF8, 0); issue("R6");
    // R7 misaligned indirect targets, each low bit
    setin(6'h04, 32'h300, 32'h0000_8001, 0); issue("R7");
    setin(6'h03, 32'h300, 32'h0000_8004, 0); issue("R7");
    setin(6'h04, 32'h300, 32'h0000_8002, 0); issue("R7");
    // R8 not-taken branch still drives the target
    br_disp = 16'h0010; setin(6'h05, 32'h400, 32'd1, 32'd2); issue("R8");
    // R9 equality compares
    setin(6'h05, 32'h400, 32'd7, 32'd7); issue("R9");
    setin(6'h06, 32'h400, 32'd7, 32'd7); issue("R9");
    setin(6'h06, 32'h400, 32'h8000_0000, 32'd0); issue("R9");
    // R10 signed compares at the zero and extreme boundaries
    for (int op = 7; op <= 10; op++) begin
      setin(6'(op), 32'h500, 32'd0, 0);          issue("R10");
      setin(6'(op), 32'h500, 32'hFFFF_FFFF, 0);  issue("R10");
      setin(6'(op), 32'h500, 32'd1, 0);          issue("R10");
      setin(6'(op), 32'h500, 32'h8000_0000, 0);  issue("R10");
      setin(6'(op), 32'h500, 32'h7FFF_FFFF, 0);  issue("R10");
    end
    // R11 floating-point flag branches
    fp_flag = 0; setin(6'h0b, 32'h600, 0, 0); issue("R11");
    fp_flag = 1; setin(6'h0b, 32'h600, 0, 0); issue("R11");
    fp_flag = 1; setin(6'h0c, 32'h600, 0, 0); issue("R11");
    fp_flag = 0; setin(6'h0c, 32'h600, 0, 0); issue("R11");
    // R12 wraparound: top of space, negative displacement below zero
    setin(6'h00, 32'hFFFF_FFF8, 0, 0); issue("R12");
    br_disp = 16'h0001; fp_flag = 0; setin(6'h0b, 32'hFFFF_FFF8, 0, 0); issue("R12");
    br_disp = 16'h8000; setin(6'h0b, 32'h0000_0010, 0, 0); issue("R12");
    jmp_field = 26'd3; setin(6'h02, 32'hFFFF_FFF8, 0, 0); issue("R12");

    // R2 hold: inputs change without a request
    hold_n = next_pc; hold_t = target_pc;
    setin(6'h01, 32'hDEAD_0000, 32'h1, 32'h2); jmp_field = 26'h123;
    @(negedge clk);
    chk("R2", "res_valid idle", {31'd0, res_valid}, 32'd0);
    chk("R2", "next_pc hold", next_pc, hold_n);
    chk("R2", "target_pc hold", target_pc, hold_t);

    // random mix, R13 covered by every issue
    for (int i = 0; i < 400; i++) begin
      opcode    = ($urandom % 8 == 0) ? 6'($urandom) : 6'($urandom % 16);
      cur_pc    = $urandom & 32'hFFFF_FFF8;
      jmp_field = 26'($urandom);
      br_disp   = 16'($urandom);
      src_a     = $urandom;
      if ($urandom % 2 == 0) src_a = src_a & 32'hFFFF_FFF8;
      if ($urandom % 4 == 0) src_a = 32'd0;
      src_b     = ($urandom % 3 == 0) ? src_a : $urandom;
      rd_idx    = 5'($urandom);
      fp_flag   = 1'($urandom);
      issue(($urandom % 2 == 0) ? "R13" : tag_of(opcode));
      if ($urandom % 3 == 0) @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (done);
    if (cyc > 100000) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule